// File: doc/BRIEF.md
# Remote Interrupt Forwarding Controller

This block sits in a serial link endpoint. It takes the interrupt level recovered from the far end of the link and turns it into two local outputs. The first output is a transparent copy of the remote level. It is forced low whenever the link is not locked. The second output is an active-low, latched host interrupt. A falling edge of the remote level arms it. Two mask bits gate it, and a read of the status register clears it.

The remote level and the lock indication arrive on the local clock. The remote level first passes through a multi-flop synchronizer. A small synchronous register port exposes a control register and a read-to-clear status register. A host has two ways to use the block. It can watch the mirror output directly and leave the remote-route bit clear. Or it can enable both mask bits and service the latched line: it reads the status register, then clears the source at the far end.

Top module: `rint_fwd_ctrl`

## Requirements
- R1: While `lock_i` is high, `mirror_o` equals the value `rem_int_i` had two clock edges earlier, because of the two-stage synchronizer.
- R2: While `lock_i` is low, `mirror_o` is low, whatever `rem_int_i` does.
- R3: A high-to-low transition of the synchronized remote level, seen while `lock_i` is high, sets the pending flag one clock later. Transitions seen while unlocked set nothing. The pending flag is reported as bit 5 of the status register.
- R4: `int_no` is low exactly when the pending flag, control bit 5 (remote route) and control bit 0 (global enable) are all 1. The pending flag latches even while it is masked.
- R5: A read of the status register at address 0xC7 returns the pending flag as it was before the read, with all other bits 0. The same read clears the flag, so `int_no` returns high on the next edge.
- R6: After a clear, a remote level that stays low does not set the flag again. Only a new falling edge does.
- R7: If a falling edge is detected in the same cycle as a status read, the read returns the old value and the pending flag stays set.
- R8: The control register sits at address 0xC6. Writes store bits 5 and 0, and reads return those bits with all other bits 0. Writes to 0xC7 have no effect.
- R9: Read data appears on `rdata_o` on the clock after `rd_en_i` and is held until the next read. A read of any address other than 0xC6 or 0xC7 returns 0.
- R10: After reset, `mirror_o` is low, `int_no` is high, `rdata_o` is 0, both control bits are 0 and no interrupt is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lock_i | input | 1 | Link-lock indication, synchronous |
| rem_int_i | input | 1 | Remote interrupt level recovered from the link |
| addr_i | input | ADDR_W | Register address |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, one cycle after the read strobe |
| mirror_o | output | 1 | Remote level mirror, low while unlocked |
| int_no | output | 1 | Latched host interrupt, active low |

## Verification
The bench builds the block with its defaults: two synchronizer stages, 8-bit address and data, and the control and status registers at 0xC6 and 0xC7. With these values the bench model can track the exact two-edge mirror latency and the three-edge delay from a remote falling edge to `int_no`. That precision lets a directed case place a status read in the very cycle the edge is detected. The 8-bit address space is also small enough that random reads reach unmapped addresses often.

// File: rtl/rint_pkg.sv
package rint_pkg;
  localparam int REM_BIT = 5;
  localparam int GIE_BIT = 0;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_ICR  = 2'd1,
    SEL_ISR  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/rint_sync.sv
module rint_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_st
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[i] <= RST_VAL;
        else         ff_q[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[i] <= RST_VAL;
        else         ff_q[i] <= ff_q[i-1];
      end
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/rint_pend.sv
module rint_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  input  logic lvl_i,
  input  logic clr_i,
  output logic fall_o,
  output logic pend_o
);
  logic prev_q;
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= lvl_i;
  end

  assign fall_o = lock_i & prev_q & ~lvl_i;

  // set wins over clear so a coincident edge is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (fall_o) pend_q <= 1'b1;
    else if (clr_i)  pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  AST_PEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> pend_o); // R3
  AST_PEND_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !fall_o) |=> !pend_o); // R5
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_o) |-> $past(fall_o)); // R6
  AST_KEEP_ON_CLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && fall_o) |=> pend_o); // R7
endmodule

// File: rtl/rint_regs.sv
module rint_regs
  import rint_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter int              DATA_W   = 8,
  parameter logic [ADDR_W-1:0] ICR_ADDR = 8'hC6,
  parameter logic [ADDR_W-1:0] ISR_ADDR = 8'hC7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pend_i,
  output logic              icr_rem_o,
  output logic              icr_gie_o,
  output logic              isr_rd_o,
  output logic [DATA_W-1:0] rdata_o
);
  reg_sel_e          sel;
  logic              icr_rem_q, icr_gie_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    if (addr_i == ICR_ADDR)      sel = SEL_ICR;
    else if (addr_i == ISR_ADDR) sel = SEL_ISR;
    else                         sel = SEL_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      icr_rem_q <= 1'b0;
      icr_gie_q <= 1'b0;
    end else if (wr_en_i && sel == SEL_ICR) begin
      icr_rem_q <= wdata_i[REM_BIT];
      icr_gie_q <= wdata_i[GIE_BIT];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_ICR: begin
        rd_mux[REM_BIT] = icr_rem_q;
        rd_mux[GIE_BIT] = icr_gie_q;
      end
      SEL_ISR: rd_mux[REM_BIT] = pend_i;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign isr_rd_o  = rd_en_i && (sel == SEL_ISR);
  assign icr_rem_o = icr_rem_q;
  assign icr_gie_o = icr_gie_q;
  assign rdata_o   = rdata_q;

  AST_RD_UNMAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && sel == SEL_NONE) |=> (rdata_o == '0)); // R9
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o)); // R9
endmodule

// File: rtl/rint_fwd_ctrl.sv
module rint_fwd_ctrl #(
  parameter int              ADDR_W      = 8,
  parameter int              DATA_W      = 8,
  parameter int              SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] ICR_ADDR  = 8'hC6,
  parameter logic [ADDR_W-1:0] ISR_ADDR  = 8'hC7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic              rem_int_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mirror_o,
  output logic              int_no
);
  logic rem_sync;
  logic fall, pend, clr;
  logic icr_rem, icr_gie;

  rint_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rem_int_i),
    .q_o   (rem_sync)
  );

  rint_pend u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lock_i(lock_i),
    .lvl_i (rem_sync),
    .clr_i (clr),
    .fall_o(fall),
    .pend_o(pend)
  );

  rint_regs #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .ICR_ADDR(ICR_ADDR),
    .ISR_ADDR(ISR_ADDR)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .wdata_i  (wdata_i),
    .pend_i   (pend),
    .icr_rem_o(icr_rem),
    .icr_gie_o(icr_gie),
    .isr_rd_o (clr),
    .rdata_o  (rdata_o)
  );

  assign mirror_o = lock_i & rem_sync;
  assign int_no   = ~(pend & icr_rem & icr_gie);

  AST_INT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !fall) |=> int_no); // R5
  AST_INT_NEEDS_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_no |-> (icr_rem && icr_gie)); // R4
endmodule

// File: tb/rint_fwd_ctrl_bench.sv
module rint_fwd_ctrl_bench;
  localparam logic [7:0] A_ICR = 8'hC6;
  localparam logic [7:0] A_ISR = 8'hC7;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       lock_i = 1'b0, rem_int_i = 1'b1;
  logic [7:0] addr_i = '0, wdata_i = '0;
  logic       wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [7:0] rdata_o;
  logic       mirror_o, int_no;

  int tests = 0, fails = 0;
  bit done = 0;
  string ctx = "reset";
  string rd_tag = "R9";

  // bench model state
  logic m_s1 = 1, m_s2 = 1, m_prev = 1, m_pend = 0, m_ic5 = 0, m_ic0 = 0;
  logic [7:0] m_rd = '0;

  always #4ns clk = ~clk;

  rint_fwd_ctrl u_rint_fwd_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .lock_i(lock_i), .rem_int_i(rem_int_i),
    .addr_i(addr_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .mirror_o(mirror_o), .int_no(int_no)
  );

  function automatic logic [7:0] exp_read(input logic [7:0] ad);
    if (ad == A_ICR)      return {2'b0, m_ic5, 4'b0, m_ic0};
    else if (ad == A_ISR) return {2'b0, m_pend, 5'b0};
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%h expected=%h t=%0t", req, ctx, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(lock_i ? "R1" : "R2", {7'b0, mirror_o}, {7'b0, lock_i & m_s2});
    chk("R4", {7'b0, int_no}, {7'b0, ~(m_pend & m_ic5 & m_ic0)});
    chk(rd_tag, rdata_o, m_rd);
  endtask

  task automatic cyc(input logic lk, input logic rm, input logic wr, input logic rd,
                     input logic [7:0] ad, input logic [7:0] wd);
    logic fall, rd_isr;
    lock_i = lk; rem_int_i = rm; wr_en_i = wr; rd_en_i = rd; addr_i = ad; wdata_i = wd;
    fall   = lk & m_prev & ~m_s2;
    rd_isr = rd && (ad == A_ISR);
    if (rd) begin
      m_rd   = exp_read(ad);
      rd_tag = (ad == A_ICR) ? "R8" : (ad == A_ISR) ? "R3/R5" : "R9";
    end
    m_pend = fall | (m_pend & ~rd_isr);
    if (wr && ad == A_ICR) begin m_ic5 = wd[5]; m_ic0 = wd[0]; end
    m_prev = m_s2; m_s2 = m_s1; m_s1 = rm;
    @(posedge clk); @(negedge clk);
    compare();
  endtask

  task automatic idle(input logic lk, input logic rm, input int n);
    for (int i = 0; i < n; i++) cyc(lk, rm, 0, 0, 8'h00, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog [%s] actual=running expected=finished", ctx);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    ctx = "R10 reset";
    chk("R10", {7'b0, mirror_o}, 8'h00);
    chk("R10", {7'b0, int_no}, 8'h01);
    chk("R10", rdata_o, 8'h00);
    rst_ni = 1'b1;
    cyc(0, 1, 0, 1, A_ICR, 0);               // R10 control bits read zero
    chk("R10", rdata_o, 8'h00);

    ctx = "R8 icr";
    cyc(0, 1, 1, 0, A_ICR, 8'hFF);
    cyc(0, 1, 0, 1, A_ICR, 0);
    chk("R8", rdata_o, 8'h21);
    cyc(0, 1, 1, 0, A_ISR, 8'hFF);           // R8 isr write ignored
    cyc(0, 1, 0, 1, A_ISR, 0);
    chk("R8", rdata_o, 8'h00);
    cyc(0, 1, 0, 1, 8'h3A, 0);               // R9 unmapped
    chk("R9", rdata_o, 8'h00);

    ctx = "R2 unlocked";
    idle(0, 0, 4); idle(0, 1, 3); idle(0, 0, 4);
    cyc(0, 0, 0, 1, A_ISR, 0);
    chk("R3", rdata_o, 8'h00);               // unlocked edge ignored
    idle(0, 1, 3);

    ctx = "R1/R3 locked edge";
    idle(1, 1, 3);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R1", {7'b0, mirror_o}, 8'h01);      // one edge in: still old level
    cyc(1, 0, 0, 0, 0, 0);
    chk("R1", {7'b0, mirror_o}, 8'h00);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R3", {7'b0, int_no}, 8'h00);
    cyc(1, 0, 0, 1, A_ISR, 0);
    chk("R5", rdata_o, 8'h20);
    chk("R5", {7'b0, int_no}, 8'h01);

    ctx = "R6 held low";
    idle(1, 0, 6);
    chk("R6", {7'b0, int_no}, 8'h01);
    cyc(1, 0, 0, 1, A_ISR, 0);
    chk("R6", rdata_o, 8'h00);

    ctx = "R7 clash";
    idle(1, 1, 4);
    cyc(1, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 1, A_ISR, 0);               // read in the detect cycle
    chk("R7", rdata_o, 8'h00);
    chk("R7", {7'b0, int_no}, 8'h00);
    cyc(1, 0, 0, 1, A_ISR, 0);
    chk("R7", rdata_o, 8'h20);

    ctx = "R4 masking";
    idle(1, 1, 3); idle(1, 0, 3);
    cyc(1, 0, 1, 0, A_ICR, 8'h20);
    chk("R4", {7'b0, int_no}, 8'h01);
    cyc(1, 0, 1, 0, A_ICR, 8'h01);
    chk("R4", {7'b0, int_no}, 8'h01);
    cyc(1, 0, 1, 0, A_ICR, 8'h21);
    chk("R4", {7'b0, int_no}, 8'h00);

    ctx = "random";
    void'($urandom(32'h5EED_1234));
    begin
      logic lk = 1, rm = 1;
      for (int i = 0; i < 5000; i++) begin
        int r;
        logic [7:0] ad;
        if ($urandom_range(0, 99) < 3)  lk = ~lk;
        if ($urandom_range(0, 99) < 15) rm = ~rm;
        r  = $urandom_range(0, 9);
        ad = (r < 4) ? A_ISR : (r < 7) ? A_ICR : 8'($urandom);
        cyc(lk, rm, $urandom_range(0, 9) == 0, $urandom_range(0, 4) == 0, ad, 8'($urandom));
      end
    end

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule